// File: doc/BRIEF.md
# Hashed Page Table Group Search

This block looks up a translation in a hashed page table held in external storage. A request carries a virtual segment identifier, a byte offset within a 256 MB segment, a page-size selector and a segment-size code. From these the block derives a primary group index and an expected abbreviated virtual page number. It then reads the eight entries of the primary group one per cycle and compares the first doubleword of each entry against the expectation. If all eight primary entries miss, it reads the eight entries of the secondary group, whose index is the complement of the primary hash.

The first matching entry ends the search. The block then returns the real page number and the protection, no-execute, referenced and changed flags from that entry's second doubleword. If neither group holds a match, the block returns a fault. Upstream, a valid/ready request handshake starts a search, and the result comes back as a one-cycle response pulse. Toward the table, the block has a read port that accepts one read per cycle and returns the data one cycle later. The block never writes the table.

Top module: `hpt_group_search`

## Requirements
- R1: `req_ready` is 1 exactly when no search is in progress. This includes the cycle that carries a response, so a new request can be accepted in that cycle. A request is accepted when `req_valid` and `req_ready` are both 1. No table read is issued in any cycle in which `req_ready` is 1.
- R2: The primary hash is `vsid ^ (offset >> shift)`. The shift is 12, 16, 20 or 24 for the page-size selector values 0 (4 KB), 1 (64 KB), 2 (1 MB) and 3 (16 MB). The primary group index is the low GROUP_W bits of the hash. The read address is `{group, slot}`, with the slot in the 3 low bits.
- R3: An entry matches only when all of the following hold in its first doubleword (`mem_rd_data[127:64]`): bit 0 (valid) is 1; bit 1 (secondary) equals the pass being searched; bit 2 (large) is 1 exactly when the selector is not 0; bits [63:62] equal `req_ssize`; and bits [61:7] equal the zero-extended value `{vsid, offset[27:23]}`. For the 16 MB selector, bit 0 of that expected value is forced to 0. Bits 3 (lock) and 4 (bolted) have no effect on matching.
- R4: Within a group, slots are read in order 0 to 7, one per cycle. When more than one entry matches, the lowest slot wins.
- R5: The secondary group index is the low GROUP_W bits of the complemented hash. It is read only after all eight primary slots miss, and it matches only entries whose secondary bit is 1.
- R6: Number the reads of a search k = 0..15, with k = 8..15 for the secondary slots 0..7. Read k is issued k+1 cycles after acceptance. A hit at read k gives `resp_valid` k+3 cycles after acceptance. A full miss gives `resp_valid` 18 cycles after acceptance, with `resp_hit` = 0 and every result field 0.
- R7: On a hit, the result fields come from the second doubleword (`mem_rd_data[63:0]`): `resp_rpn` from bits [61:12], `resp_pp` from bits [1:0], `resp_noexec` from bit 2, `resp_chg` from bit 7 and `resp_ref` from bit 8. `resp_secondary` is 1 when the match was in the secondary group.
- R8: `resp_valid` is high for exactly one cycle per accepted request and never without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_vsid | input | VSID_W | Virtual segment identifier |
| req_offset | input | 28 | Byte offset within the 256 MB segment |
| req_psize | input | 2 | Page-size selector: 0 = 4 KB, 1 = 64 KB, 2 = 1 MB, 3 = 16 MB |
| req_ssize | input | 2 | Segment-size code the entry must carry |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | 1 = translation found, 0 = fault |
| resp_secondary | output | 1 | Match came from the secondary group |
| resp_rpn | output | 50 | Real page number |
| resp_pp | output | 2 | Protection pair |
| resp_noexec | output | 1 | No-execute flag |
| resp_ref | output | 1 | Referenced flag |
| resp_chg | output | 1 | Changed flag |
| mem_rd_en | output | 1 | Table read strobe |
| mem_rd_addr | output | GROUP_W+3 | Entry address `{group, slot}` |
| mem_rd_data | input | 128 | Entry returned one cycle after the read: first doubleword in [127:64], second in [63:0] |

## Verification
Every search has a fixed latency. The response comes k+3 cycles after acceptance when the hit is at read k, and 18 cycles after acceptance on a fault. The bench records the acceptance cycle for each request, computes k from its own table image, and queues the due cycle together with the expected fields. On every falling edge it compares `resp_valid` and `req_ready` against that queue. All fields are checked in the due cycle, and any pulse in another cycle is counted as a failure. Tests cover near-miss entries, a duplicate match, secondary-group hits including the last slot, a full fault and the 16 MB low-bit clear, and new requests are issued in the response cycle.

// File: rtl/hpt_pkg.sv
// Package: shared constants, types and helpers for the hashed page table
// group search. Assumes 64-bit table doublewords and 256 MB segments.
package hpt_pkg;
    localparam int DW_W       = 64;
    localparam int OFF_W      = 28;
    localparam int SLOT_W     = 3;
    localparam int AVPN_LO    = 7;
    localparam int AVPN_HI    = 61;
    localparam int AVPN_FLD_W = AVPN_HI - AVPN_LO + 1;
    localparam int AVPN_CUT   = 23;
    localparam int RPN_LO     = 12;
    localparam int RPN_HI     = 61;
    localparam int RPN_W      = RPN_HI - RPN_LO + 1;

    typedef enum logic [1:0] {
        PG_4K  = 2'd0,
        PG_64K = 2'd1,
        PG_1M  = 2'd2,
        PG_16M = 2'd3
    } pgsel_e;

    typedef struct packed {
        logic             secondary;
        logic [RPN_W-1:0] rpn;
        logic [1:0]       pp;
        logic             noexec;
        logic             refd;
        logic             chg;
    } hpt_result_t;

    // Page shift for a size selector: 12, 16, 20 or 24.
    function automatic int unsigned page_shift(input logic [1:0] sel);
        return 32'd12 + 32'd4 * 32'(sel);
    endfunction
endpackage

// File: rtl/hpt_hash_gen.sv
// Module: hpt_hash_gen
// Computes the primary and secondary group indices and the expected
// abbreviated virtual page number from a latched request.
// Assumes VSID_W >= the offset width and GROUP_W <= VSID_W.
module hpt_hash_gen #(
    parameter int VSID_W  = 39,
    parameter int GROUP_W = 5,
    parameter int AVPN_W  = VSID_W + hpt_pkg::OFF_W - hpt_pkg::AVPN_CUT
) (
    input  logic [VSID_W-1:0]         vsid,
    input  logic [hpt_pkg::OFF_W-1:0] offset,
    input  logic [1:0]                psize,
    output logic [GROUP_W-1:0]        prim_grp,
    output logic [GROUP_W-1:0]        sec_grp,
    output logic [AVPN_W-1:0]         exp_avpn,
    output logic                      exp_large
);
    import hpt_pkg::*;

    logic [OFF_W-1:0]  page_idx;
    logic [VSID_W-1:0] hash;
    int unsigned       shift;

    // Offset shifted down by the page shift selected by psize.
    always_comb begin
        shift    = page_shift(psize);
        page_idx = offset >> shift;
    end

    // Primary hash and the two group indices.
    always_comb begin
        hash     = vsid ^ VSID_W'(page_idx);
        prim_grp = hash[GROUP_W-1:0];
        sec_grp  = ~hash[GROUP_W-1:0];
    end

    // Expected page number: address above bit 23, low bits below the page size cleared.
    always_comb begin
        exp_avpn = {vsid, offset[OFF_W-1:AVPN_CUT]};
        for (int i = 0; i < 2; i++) begin
            if (32'(i) + 32'(AVPN_CUT) < shift) exp_avpn[i] = 1'b0;
        end
        exp_large = (psize != PG_4K);
    end
endmodule

// File: rtl/hpt_entry_match.sv
// Module: hpt_entry_match
// Compares the first doubleword of one table entry against the
// expected tag for the pass being searched. Purely combinational.
module hpt_entry_match #(
    parameter int AVPN_W = 44
) (
    input  logic [hpt_pkg::DW_W-1:0] dw0,
    input  logic [AVPN_W-1:0]        exp_avpn,
    input  logic                     exp_large,
    input  logic [1:0]               ssize,
    input  logic                     want_sec,
    output logic                     hit
);
    import hpt_pkg::*;

    logic fld_ok;
    logic tag_ok;

    // Flag checks: valid set, secondary bit equal to the pass, large bit equal to the size class.
    always_comb begin
        fld_ok = dw0[0] && (dw0[1] == want_sec) && (dw0[2] == exp_large)
                 && (dw0[DW_W-1:DW_W-2] == ssize);
    end

    // Page number field comparison over bits [61:7].
    always_comb begin
        tag_ok = (dw0[AVPN_HI:AVPN_LO] == AVPN_FLD_W'(exp_avpn));
        hit    = fld_ok && tag_ok;
    end
endmodule

// File: rtl/hpt_search_ctrl.sv
// Module: hpt_search_ctrl
// Sequences the 16 reads (8 primary, then 8 secondary), tracks the
// read in flight and forms the response. Assumes the table returns data
// exactly one cycle after a read strobe.
module hpt_search_ctrl #(
    parameter int GROUP_W = 5,
    parameter int ADDR_W  = GROUP_W + hpt_pkg::SLOT_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    output logic                       accept,
    input  logic [GROUP_W-1:0]         prim_grp,
    input  logic [GROUP_W-1:0]         sec_grp,
    input  logic                       cmp_hit,
    input  logic [hpt_pkg::DW_W-1:0]   dw1,
    output logic                       want_sec,
    output logic                       rd_en,
    output logic [ADDR_W-1:0]          rd_addr,
    output logic                       resp_valid,
    output logic                       resp_hit,
    output hpt_pkg::hpt_result_t       resp_res
);
    import hpt_pkg::*;

    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_DRAIN} st_e;

    localparam int CNT_W = SLOT_W + 1;

    st_e              state;
    logic [CNT_W-1:0] cnt;
    logic             pend_valid;
    logic             pend_sec;

    // Handshake and read-port drive.
    always_comb begin
        req_ready = (state == ST_IDLE);
        accept    = req_valid && req_ready;
        rd_en     = (state == ST_ISSUE);
        rd_addr   = {(cnt[CNT_W-1] ? sec_grp : prim_grp), cnt[SLOT_W-1:0]};
        want_sec  = pend_sec;
    end

    // Search sequencing, in-flight tracking and response capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            pend_valid <= 1'b0;
            pend_sec   <= 1'b0;
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_res   <= '0;
        end else begin
            resp_valid <= 1'b0;
            pend_valid <= rd_en;
            pend_sec   <= cnt[CNT_W-1];
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state <= ST_ISSUE;
                        cnt   <= '0;
                    end
                end
                ST_ISSUE: begin
                    cnt <= cnt + 1'b1;
                    if (&cnt) state <= ST_DRAIN;
                end
                default: ;
            endcase
            if (pend_valid && cmp_hit) begin
                state              <= ST_IDLE;
                pend_valid         <= 1'b0;
                resp_valid         <= 1'b1;
                resp_hit           <= 1'b1;
                resp_res.secondary <= pend_sec;
                resp_res.rpn       <= dw1[RPN_HI:RPN_LO];
                resp_res.pp        <= dw1[1:0];
                resp_res.noexec    <= dw1[2];
                resp_res.chg       <= dw1[7];
                resp_res.refd      <= dw1[8];
            end else if (pend_valid && state == ST_DRAIN) begin
                state      <= ST_IDLE;
                pend_valid <= 1'b0;
                resp_valid <= 1'b1;
                resp_hit   <= 1'b0;
                resp_res   <= '0;
            end
        end
    end
endmodule

// File: rtl/hpt_group_search.sv
// Module: hpt_group_search (top)
// Latches a lookup request, derives hash and tag, and drives the search
// controller and entry comparator. Table data: first doubleword in
// [127:64], second in [63:0], returned one cycle after mem_rd_en.
module hpt_group_search #(
    parameter int VSID_W  = 39,
    parameter int GROUP_W = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [VSID_W-1:0]          req_vsid,
    input  logic [27:0]                req_offset,
    input  logic [1:0]                 req_psize,
    input  logic [1:0]                 req_ssize,
    output logic                       resp_valid,
    output logic                       resp_hit,
    output logic                       resp_secondary,
    output logic [49:0]                resp_rpn,
    output logic [1:0]                 resp_pp,
    output logic                       resp_noexec,
    output logic                       resp_ref,
    output logic                       resp_chg,
    output logic                       mem_rd_en,
    output logic [GROUP_W+2:0]         mem_rd_addr,
    input  logic [127:0]               mem_rd_data
);
    import hpt_pkg::*;

    localparam int AVPN_W = VSID_W + OFF_W - AVPN_CUT;
    localparam int ADDR_W = GROUP_W + SLOT_W;

    logic [VSID_W-1:0]  q_vsid;
    logic [OFF_W-1:0]   q_off;
    logic [1:0]         q_psize;
    logic [1:0]         q_ssize;
    logic               accept;
    logic [GROUP_W-1:0] prim_grp;
    logic [GROUP_W-1:0] sec_grp;
    logic [AVPN_W-1:0]  exp_avpn;
    logic               exp_large;
    logic               want_sec;
    logic               cmp_hit;
    logic [ADDR_W-1:0]  rd_addr;
    hpt_result_t        res;

    // Hold the request fields for the whole search.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_vsid  <= '0;
            q_off   <= '0;
            q_psize <= '0;
            q_ssize <= '0;
        end else if (accept) begin
            q_vsid  <= req_vsid;
            q_off   <= req_offset;
            q_psize <= req_psize;
            q_ssize <= req_ssize;
        end
    end

    hpt_hash_gen #(.VSID_W(VSID_W), .GROUP_W(GROUP_W), .AVPN_W(AVPN_W)) u_hash (
        .vsid      (q_vsid),
        .offset    (q_off),
        .psize     (q_psize),
        .prim_grp  (prim_grp),
        .sec_grp   (sec_grp),
        .exp_avpn  (exp_avpn),
        .exp_large (exp_large)
    );

    hpt_entry_match #(.AVPN_W(AVPN_W)) u_match (
        .dw0       (mem_rd_data[2*DW_W-1:DW_W]),
        .exp_avpn  (exp_avpn),
        .exp_large (exp_large),
        .ssize     (q_ssize),
        .want_sec  (want_sec),
        .hit       (cmp_hit)
    );

    hpt_search_ctrl #(.GROUP_W(GROUP_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .accept     (accept),
        .prim_grp   (prim_grp),
        .sec_grp    (sec_grp),
        .cmp_hit    (cmp_hit),
        .dw1        (mem_rd_data[DW_W-1:0]),
        .want_sec   (want_sec),
        .rd_en      (mem_rd_en),
        .rd_addr    (rd_addr),
        .resp_valid (resp_valid),
        .resp_hit   (resp_hit),
        .resp_res   (res)
    );

    // Unpack the response record onto the ports.
    always_comb begin
        mem_rd_addr    = rd_addr;
        resp_secondary = res.secondary;
        resp_rpn       = res.rpn;
        resp_pp        = res.pp;
        resp_noexec    = res.noexec;
        resp_ref       = res.refd;
        resp_chg       = res.chg;
    end
endmodule

// File: rtl/hpt_group_search_chk.sv
// Module: hpt_group_search_chk
// Port-level protocol checks for hpt_group_search, attached by bind.
module hpt_group_search_chk #(
    parameter int GROUP_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic               resp_valid,
    input logic               resp_hit,
    input logic [49:0]        resp_rpn,
    input logic [1:0]         resp_pp,
    input logic               mem_rd_en,
    input logic [GROUP_W+2:0] mem_rd_addr
);
    // R1: no read issued while the block is idle
    a_r1_idle_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_rd_en);

    // R6: first read of a search is slot 0, one cycle after acceptance
    a_r6_first_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_rd_en && mem_rd_addr[2:0] == 3'd0));

    // R4: back-to-back reads step through the slots in order
    a_r4_slot_order: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && $past(mem_rd_en) && mem_rd_addr[2:0] != 3'd0)
        |-> (mem_rd_addr[2:0] == $past(mem_rd_addr[2:0]) + 3'd1));

    // R5: the pass switch comes right after slot 7
    a_r5_pass_switch: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && $past(mem_rd_en) && mem_rd_addr[2:0] == 3'd0)
        |-> ($past(mem_rd_addr[2:0]) == 3'd7));

    // R8: response is a single-cycle pulse
    a_r8_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R1: ready is asserted in the response cycle
    a_r1_ready_with_resp: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> req_ready);

    // R6: a fault carries zero result fields
    a_r6_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit) |-> (resp_rpn == '0 && resp_pp == 2'd0));
endmodule

bind hpt_group_search hpt_group_search_chk #(.GROUP_W(GROUP_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .resp_valid  (resp_valid),
    .resp_hit    (resp_hit),
    .resp_rpn    (resp_rpn),
    .resp_pp     (resp_pp),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr)
);

// File: tb/hpt_group_search_bench.sv
// Bench: table image, behavioural lookup model, per-cycle response checks.
module hpt_group_search_bench;
    localparam int G  = 5;
    localparam int NE = 1 << (G + 3);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [38:0]  req_vsid = '0;
    logic [27:0]  req_offset = '0;
    logic [1:0]   req_psize = '0;
    logic [1:0]   req_ssize = '0;
    logic         resp_valid, resp_hit, resp_secondary;
    logic [49:0]  resp_rpn;
    logic [1:0]   resp_pp;
    logic         resp_noexec, resp_ref, resp_chg;
    logic         mem_rd_en;
    logic [G+2:0] mem_rd_addr;
    logic [127:0] mem_rd_data = '0;

    logic [127:0] mem [NE];

    int cyc = 0;
    int nchk = 0;
    int nerr = 0;
    bit chk_on = 1'b0;

    typedef struct {
        int          due;
        bit          hit;
        bit          sec;
        logic [49:0] rpn;
        logic [1:0]  pp;
        bit          n, r, c;
        string       tag;
    } exp_t;
    exp_t q[$];

    hpt_group_search #(.VSID_W(39), .GROUP_W(G)) u_hpt_group_search (.*);

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Table storage: one-cycle read latency
    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] got, input logic [63:0] expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, expv);
        end
    endtask

    function automatic logic [G-1:0] grp_of(input logic [38:0] v, input logic [27:0] o,
                                            input logic [1:0] p, input bit sec);
        logic [38:0] h;
        h = v ^ {11'b0, o >> (12 + 4 * p)};
        return sec ? ~h[G-1:0] : h[G-1:0];
    endfunction

    function automatic logic [43:0] avpn_of(input logic [38:0] v, input logic [27:0] o,
                                            input logic [1:0] p);
        logic [43:0] a;
        a = {v, o[27:23]};
        if (p == 2'd3) a[0] = 1'b0;
        return a;
    endfunction

    function automatic logic [63:0] mk0(input logic [43:0] a, input logic [1:0] ss,
                                        input bit sec, input bit lg, input bit vld, input bit extra);
        return {ss, 11'b0, a, 2'b0, extra, extra, lg, sec, vld};
    endfunction

    function automatic logic [63:0] mk1(input logic [49:0] rpn, input logic [1:0] pp,
                                        input bit n, input bit r, input bit c);
        return {2'b0, rpn, 3'b0, r, c, 4'b0, n, pp};
    endfunction

    task automatic put(input logic [G-1:0] g, input int slot, input logic [63:0] d0,
                       input logic [63:0] d1);
        mem[{g, 3'(slot)}] = {d0, d1};
    endtask

    task automatic clear_mem();
        for (int i = 0; i < NE; i++) mem[i] = '0;
    endtask

    // Send one request at a falling edge; wait until its response cycle.
    task automatic run(input logic [38:0] v, input logic [27:0] o, input logic [1:0] p,
                       input logic [1:0] s, input string tag);
        exp_t e;
        int   c0;
        bit   found;
        int   k;
        logic [63:0] d0, d1;
        found = 1'b0;
        k = 16;
        e.hit = 1'b0; e.sec = 1'b0; e.rpn = '0; e.pp = '0; e.n = 1'b0; e.r = 1'b0; e.c = 1'b0;
        for (int pass = 0; pass < 2 && !found; pass++) begin
            for (int sl = 0; sl < 8 && !found; sl++) begin
                d0 = mem[{grp_of(v, o, p, pass[0]), 3'(sl)}][127:64];
                d1 = mem[{grp_of(v, o, p, pass[0]), 3'(sl)}][63:0];
                if (d0[0] && d0[1] == pass[0] && d0[2] == (p != 2'd0) && d0[63:62] == s
                    && d0[61:7] == 55'(avpn_of(v, o, p))) begin
                    found = 1'b1;
                    k = pass * 8 + sl;
                    e.hit = 1'b1; e.sec = pass[0]; e.rpn = d1[61:12]; e.pp = d1[1:0];
                    e.n = d1[2]; e.r = d1[8]; e.c = d1[7];
                end
            end
        end
        e.tag = tag;
        req_vsid = v; req_offset = o; req_psize = p; req_ssize = s; req_valid = 1'b1;
        c0 = cyc;
        e.due = found ? c0 + k + 3 : c0 + 18;
        @(posedge clk);
        q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
        while (cyc < e.due) @(negedge clk);
    endtask

    // Reference comparison on every clock
    always @(negedge clk) begin
        if (chk_on) begin
            if (q.size() > 0 && q[0].due == cyc) begin
                exp_t e;
                e = q.pop_front();
                chk(resp_valid == 1'b1, e.tag, "R6 resp_valid in due cycle", 64'(resp_valid), 64'd1);
                chk(resp_hit == e.hit, e.tag, "hit", 64'(resp_hit), 64'(e.hit));
                chk(resp_secondary == e.sec, e.tag, "R7 secondary", 64'(resp_secondary), 64'(e.sec));
                chk(resp_rpn == e.rpn, e.tag, "R7 rpn", 64'(resp_rpn), 64'(e.rpn));
                chk({resp_pp, resp_noexec, resp_ref, resp_chg} == {e.pp, e.n, e.r, e.c},
                    e.tag, "R7 flags", 64'({resp_pp, resp_noexec, resp_ref, resp_chg}),
                    64'({e.pp, e.n, e.r, e.c}));
                chk(req_ready == 1'b1, e.tag, "R1 ready in response cycle", 64'(req_ready), 64'd1);
            end else begin
                chk(resp_valid == 1'b0, "R8", "no spurious response", 64'(resp_valid), 64'd0);
                chk(req_ready == (q.size() == 0), "R1", "ready tracks search",
                    64'(req_ready), 64'(q.size() == 0));
            end
        end
    end

    initial begin
        #(20 * 20000);
        nerr++;
        $display("FAIL watchdog expired: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [38:0] v;
        logic [27:0] o;
        clear_mem();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "reset ready", 64'(req_ready), 64'd1);
        chk(resp_valid == 1'b0, "R8", "reset resp_valid", 64'(resp_valid), 64'd0);
        chk(mem_rd_en == 1'b0, "R1", "reset read strobe", 64'(mem_rd_en), 64'd0);
        chk_on = 1'b1;

        // R2 R3: 4 KB primary hit in slot 0
        v = 39'h12_3456_789A; o = 28'h0ABC_DEF;
        put(grp_of(v, o, 0, 0), 0, mk0(avpn_of(v, o, 0), 2'd0, 0, 0, 1, 0),
            mk1(50'h1_2345_6789_ABCD, 2'd2, 1, 0, 1));
        run(v, o, 2'd0, 2'd0, "R2");

        // R3: 64 KB, near misses in slots 0..4, lock and bolted set on the hit
        clear_mem();
        v = 39'h7F_0F0F_1234; o = 28'hF12_3456;
        put(grp_of(v, o, 1, 0), 0, mk0(avpn_of(v, o, 1), 2'd1, 0, 1, 0, 0), mk1(50'h11, 1, 0, 0, 0));
        put(grp_of(v, o, 1, 0), 1, mk0(avpn_of(v, o, 1), 2'd1, 1, 1, 1, 0), mk1(50'h22, 1, 0, 0, 0));
        put(grp_of(v, o, 1, 0), 2, mk0(avpn_of(v, o, 1), 2'd0, 0, 1, 1, 0), mk1(50'h33, 1, 0, 0, 0));
        put(grp_of(v, o, 1, 0), 3, mk0(avpn_of(v, o, 1), 2'd1, 0, 0, 1, 0), mk1(50'h44, 1, 0, 0, 0));
        put(grp_of(v, o, 1, 0), 4, mk0(avpn_of(v, o, 1) ^ 44'h100, 2'd1, 0, 1, 1, 0), mk1(50'h55, 1, 0, 0, 0));
        put(grp_of(v, o, 1, 0), 5, mk0(avpn_of(v, o, 1), 2'd1, 0, 1, 1, 1), mk1(50'h3_FFFF_0000_0001, 3, 0, 1, 0));
        run(v, o, 2'd1, 2'd1, "R3");

        // R4: 1 KB-group duplicate match, lowest slot wins (1 MB pages)
        clear_mem();
        v = 39'h00_0000_4321; o = 28'h8765_432;
        put(grp_of(v, o, 2, 0), 6, mk0(avpn_of(v, o, 2), 2'd0, 0, 1, 1, 0), mk1(50'h666, 0, 1, 1, 1));
        put(grp_of(v, o, 2, 0), 2, mk0(avpn_of(v, o, 2), 2'd0, 0, 1, 1, 0), mk1(50'h222, 1, 0, 1, 1));
        run(v, o, 2'd2, 2'd0, "R4");

        // R5: secondary hit; primary entries with secondary bit and a secondary entry without it ignored
        clear_mem();
        v = 39'h55_AAAA_5555; o = 28'h123_4567;
        for (int i = 0; i < 8; i++)
            put(grp_of(v, o, 0, 0), i, mk0(avpn_of(v, o, 0), 2'd0, 1, 0, 1, 0), mk1(50'h99, 0, 0, 0, 0));
        put(grp_of(v, o, 0, 1), 1, mk0(avpn_of(v, o, 0), 2'd0, 0, 0, 1, 0), mk1(50'h98, 0, 0, 0, 0));
        put(grp_of(v, o, 0, 1), 3, mk0(avpn_of(v, o, 0), 2'd0, 1, 0, 1, 0), mk1(50'h2_0000_0000_0003, 2, 1, 1, 0));
        run(v, o, 2'd0, 2'd0, "R5");

        // R6: nothing present, fault after both groups
        clear_mem();
        run(39'h01_0203_0405, 28'h060_7080, 2'd1, 2'd0, "R6");

        repeat (3) @(negedge clk);

        // R3: 16 MB, entry with low tag bit set misses, cleared one hits
        clear_mem();
        v = 39'h3C_C3C3_0001; o = 28'h0800_000 | 28'h0F0_0000;
        put(grp_of(v, o, 3, 0), 0, mk0(avpn_of(v, o, 3) | 44'h1, 2'd0, 0, 1, 1, 0), mk1(50'h7, 0, 0, 0, 0));
        put(grp_of(v, o, 3, 0), 1, mk0(avpn_of(v, o, 3), 2'd0, 0, 1, 1, 0), mk1(50'hABC, 3, 1, 0, 1));
        run(v, o, 2'd3, 2'd0, "R3");

        // R5 R6: last secondary slot hits at the latest cycle
        clear_mem();
        v = 39'h0F_FFFF_FFF0; o = 28'hFFF_FFFF;
        put(grp_of(v, o, 1, 1), 7, mk0(avpn_of(v, o, 1), 2'd2, 1, 1, 1, 0), mk1(50'h1_0000, 1, 1, 1, 1));
        run(v, o, 2'd1, 2'd2, "R6");

        // R7: primary slot 7 hit with distinct flags
        clear_mem();
        v = 39'h2A_2A2A_2A2A; o = 28'h555_5555;
        put(grp_of(v, o, 2, 0), 7, mk0(avpn_of(v, o, 2), 2'd3, 0, 1, 1, 0), mk1(50'h2_AAAA_AAAA_AAAA, 0, 0, 1, 0));
        run(v, o, 2'd2, 2'd3, "R7");

        // R8: idle gap, then another fault back-to-back with a hit
        repeat (4) @(negedge clk);
        clear_mem();
        run(39'h11_1111_1111, 28'h222_2222, 2'd0, 2'd1, "R8");
        v = 39'h33_3333_3333; o = 28'h444_4444;
        put(grp_of(v, o, 0, 0), 4, mk0(avpn_of(v, o, 0), 2'd1, 0, 0, 1, 0), mk1(50'h4444, 2, 0, 0, 1));
        run(v, o, 2'd0, 2'd1, "R8");

        repeat (5) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule